// File: doc/BRIEF.md
# Four-Operand Carry-Save Adder

This block is a purely combinational adder that takes four unsigned N-bit operands and returns their exact sum on N+2 bits. Two rows of full adders reduce the four operands to a sum vector and a carry vector. No carry travels along a row: every full adder in a row passes its carry to the next higher bit of the row below. A single carry-propagate adder resolves the last pair of vectors.

The final adder is chosen at build time. The cheap option is a ripple chain. The fast option is a hybrid carry-select adder. Its lowest section computes its outgoing carry with a group lookahead. Every higher section adds twice, once with carry-in 0 and once with carry-in 1, and a multiplexer picks one result using the incoming section carry. The section width is a parameter, and the top section may be narrower than the others.

Top module: `quad_csa_adder`

## Requirements
- R1: For any operands, sum_o equals a_i+b_i+c_i+d_i, zero-extended to N+2 bits.
- R2: When all four operands are all ones, sum_o equals 4*(2^N-1), with bit N+1 set and bits 1..0 clear.
- R3: When all four operands are zero, sum_o is zero.
- R4: A carry that enters the lowest section reaches every higher section. With a_i all ones, b_i equal to 1 and the others zero, sum_o equals 2^N.
- R5: Ripple-final and carry-select-final builds give the same sum_o for the same operands.
- R6: The sum stays exact when the final adder width N+1 is not a multiple of the section width.
- R7: Bit N+1 of sum_o is set exactly when the true sum is at least 2^(N+1).
- R8: Each operand carries equal weight. A single nonzero operand, placed in any of the four input positions with the rest zero, appears unchanged on sum_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand, unsigned |
| b_i | input | N | Second operand, unsigned |
| c_i | input | N | Third operand, fed to the first row in the carry-in role |
| d_i | input | N | Fourth operand, joins at the second row |
| sum_o | output | N+2 | Exact sum of the four operands |

## Verification
Two things can happen in the same evaluation: the carry-save rows produce a carry that lands in the top bit position, and the final adder produces a carry that crosses every section boundary. Operands that are all ones, or that are all ones except one low bit, make both happen at once. The bench then checks the top two result bits against a 64-bit reference sum. Random operands are also applied in parallel to a ripple-final build and to a narrow build whose top section is short, and their results must match the same reference.

// File: rtl/qcsa_pkg.sv
package qcsa_pkg;
  typedef enum logic {
    FIN_RIPPLE = 1'b0,
    FIN_CSEL   = 1'b1
  } fin_kind_e;
endpackage

// File: rtl/add_rca.sv
module add_rca #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] cv;

  always_comb begin
    cv[0] = ci_i;
    for (int i = 0; i < W; i++) begin
      s_o[i]  = a_i[i] ^ b_i[i] ^ cv[i];
      cv[i+1] = (a_i[i] & b_i[i]) | (cv[i] & (a_i[i] ^ b_i[i]));
    end
  end

  assign co_o = cv[W];
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o   // bit i carries weight 2^(i+1)
);
  always_comb begin
    for (int i = 0; i < W; i++) begin
      s_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
      c_o[i] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
    end
  end

  always_comb begin
    AST_ROW_VALUE: assert (({2'b00, s_o} + {1'b0, c_o, 1'b0}) ==
                           ({2'b00, x_i} + {2'b00, y_i} + {2'b00, z_i})); // R1
  end
endmodule

// File: rtl/add_csel.sv
module add_csel #(
  parameter int W     = 33,
  parameter int SEC_W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  localparam int NSEC  = (W + SEC_W - 1) / SEC_W;
  localparam int LOW_W = (W < SEC_W) ? W : SEC_W;

  logic [NSEC:0] sec_c;
  logic          low_co;
  logic          grp_g, grp_p;

  assign sec_c[0] = ci_i;

  add_rca #(.W(LOW_W)) low_add (
    .a_i (a_i[LOW_W-1:0]),
    .b_i (b_i[LOW_W-1:0]),
    .ci_i(ci_i),
    .s_o (s_o[LOW_W-1:0]),
    .co_o(low_co)
  );

  // section carry from group generate/propagate, in parallel with the ripple
  always_comb begin
    grp_g = 1'b0;
    grp_p = 1'b1;
    for (int i = 0; i < LOW_W; i++) begin
      grp_g = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & grp_g);
      grp_p = grp_p & (a_i[i] ^ b_i[i]);
    end
  end

  assign sec_c[1] = grp_g | (grp_p & ci_i);

  for (genvar j = 1; j < NSEC; j++) begin : g_sec
    localparam int LO = j * SEC_W;
    localparam int WJ = ((W - LO) < SEC_W) ? (W - LO) : SEC_W;
    logic [WJ-1:0] s_zero, s_one;
    logic          c_zero, c_one;

    add_rca #(.W(WJ)) add_zero (
      .a_i (a_i[LO +: WJ]),
      .b_i (b_i[LO +: WJ]),
      .ci_i(1'b0),
      .s_o (s_zero),
      .co_o(c_zero)
    );

    add_rca #(.W(WJ)) add_one (
      .a_i (a_i[LO +: WJ]),
      .b_i (b_i[LO +: WJ]),
      .ci_i(1'b1),
      .s_o (s_one),
      .co_o(c_one)
    );

    assign s_o[LO +: WJ] = sec_c[j] ? s_one : s_zero;
    assign sec_c[j+1]    = sec_c[j] ? c_one : c_zero;
  end

  assign co_o = sec_c[NSEC];

  always_comb begin
    AST_LOOKAHEAD_AGREES: assert (low_co == sec_c[1]); // R4
    AST_CSEL_EXACT: assert ({co_o, s_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i})); // R5
  end
endmodule

// File: rtl/quad_csa_adder.sv
module quad_csa_adder
  import qcsa_pkg::*;
#(
  parameter int        N        = 32,
  parameter int        SEC_W    = 8,
  parameter fin_kind_e FIN_KIND = FIN_CSEL
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  input  logic [N-1:0] d_i,
  output logic [N+1:0] sum_o
);
  localparam int FW = N + 1;

  logic [N-1:0]  s1, c1;
  logic [FW-1:0] k1, s2, c2, k2, fin_s;
  logic          fin_co;

  csa_row #(.W(N)) row_top (
    .x_i(a_i), .y_i(b_i), .z_i(c_i),
    .s_o(s1),  .c_o(c1)
  );

  assign k1 = {c1, 1'b0};

  csa_row #(.W(FW)) row_mid (
    .x_i({1'b0, s1}), .y_i(k1), .z_i({1'b0, d_i}),
    .s_o(s2),         .c_o(c2)
  );

  assign k2 = {c2[FW-2:0], 1'b0};

  if (FIN_KIND == FIN_RIPPLE) begin : g_fin_rca
    add_rca #(.W(FW)) fin_add (
      .a_i(s2), .b_i(k2), .ci_i(1'b0), .s_o(fin_s), .co_o(fin_co)
    );
  end else begin : g_fin_csel
    add_csel #(.W(FW), .SEC_W(SEC_W)) fin_add (
      .a_i(s2), .b_i(k2), .ci_i(1'b0), .s_o(fin_s), .co_o(fin_co)
    );
  end

  assign sum_o = {fin_co, fin_s};

  always_comb begin
    AST_TOP_CARRY_ZERO: assert (c2[FW-1] == 1'b0); // R1
    AST_SUM_EXACT: assert (sum_o == ({2'b00, a_i} + {2'b00, b_i} +
                                     {2'b00, c_i} + {2'b00, d_i})); // R1
    AST_NO_OVERFLOW: assert (!sum_o[N+1] ||
                             ({1'b0, sum_o[N:0]} <= ({1'b0, {FW{1'b1}}} - (N+2)'(3)))); // R2
  end
endmodule

// File: tb/quad_csa_adder_tb_top.sv
module quad_csa_adder_tb_top;
  import qcsa_pkg::*;

  localparam int N  = 32;
  localparam int NS = 13;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]  a, b, c, d;
  logic [N+1:0]  sum_cs, sum_rc;
  logic [NS+1:0] sum_nr;

  int total = 0;
  int bad   = 0;

  quad_csa_adder #(.N(N), .SEC_W(8), .FIN_KIND(FIN_CSEL)) dut_i (
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .sum_o(sum_cs)
  );

  quad_csa_adder #(.N(N), .SEC_W(8), .FIN_KIND(FIN_RIPPLE)) rca_i (
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .sum_o(sum_rc)
  );

  quad_csa_adder #(.N(NS), .SEC_W(4), .FIN_KIND(FIN_CSEL)) nar_i (
    .a_i(a[NS-1:0]), .b_i(b[NS-1:0]), .c_i(c[NS-1:0]), .d_i(d[NS-1:0]),
    .sum_o(sum_nr)
  );

  function automatic logic [63:0] ref_sum(input logic [63:0] x, y, z, w);
    return x + y + z + w;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (a=%h b=%h c=%h d=%h)", req, got, exp, a, b, c, d);
    end
  endtask

  task automatic apply(input logic [N-1:0] x, y, z, w);
    @(posedge clk);
    a = x; b = y; c = z; d = w;
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [63:0] e, en;
    e  = ref_sum({32'd0, a}, {32'd0, b}, {32'd0, c}, {32'd0, d});
    en = ref_sum({51'd0, a[NS-1:0]}, {51'd0, b[NS-1:0]},
                 {51'd0, c[NS-1:0]}, {51'd0, d[NS-1:0]});
    check(req, {30'd0, sum_cs}, e);
    check("R5", {30'd0, sum_rc}, {30'd0, sum_cs});
    check("R6", {49'd0, sum_nr}, en);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] ones;
    ones = '1;
    a = '0; b = '0; c = '0; d = '0;
    void'($urandom(32'd1234));

    apply('0, '0, '0, '0);
    check("R3", {30'd0, sum_cs}, 64'd0);
    check_all("R3");

    apply(ones, ones, ones, ones);
    check("R2", {30'd0, sum_cs}, 64'h3_FFFF_FFFC);
    check("R7", {63'd0, sum_cs[N+1]}, 64'd1);
    check_all("R2");

    apply(ones, 32'd1, '0, '0);
    check("R4", {30'd0, sum_cs}, 64'h1_0000_0000);
    check_all("R4");

    apply(ones, ones, ones, 32'hFFFF_FFFE);
    check_all("R1");

    apply(ones, ones, '0, 32'd2);
    check("R7", {63'd0, sum_cs[N+1]}, 64'd1);
    apply(ones, ones, '0, 32'd1);
    check("R7", {63'd0, sum_cs[N+1]}, 64'd0);
    check_all("R7");

    apply(32'h1234_5678, '0, '0, '0);
    check("R8", {30'd0, sum_cs}, 64'h1234_5678);
    apply('0, 32'h1234_5678, '0, '0);
    check("R8", {30'd0, sum_cs}, 64'h1234_5678);
    apply('0, '0, 32'h1234_5678, '0);
    check("R8", {30'd0, sum_cs}, 64'h1234_5678);
    apply('0, '0, '0, 32'h1234_5678);
    check("R8", {30'd0, sum_cs}, 64'h1234_5678);

    apply(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000);
    check_all("R1");

    for (int i = 0; i < 3000; i++) begin
      apply($urandom, $urandom, $urandom, $urandom);
      check_all("R1");
    end

    for (int i = 0; i < 500; i++) begin
      apply(ones ^ (32'd1 << ($urandom % 32)), ones, ones ^ $urandom % 4, $urandom);
      check_all("R7");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule